// File: doc/BRIEF.md
# Store Queue with Vector-Entry Validity

This block holds stores in program order between dispatch and the store buffer. Scalar and vector store micro-ops reserve entries in a 16-slot ring when they are dispatched. The address pipeline and the data pipeline then write their results into those entries by index. A commit pulse marks the oldest uncommitted entry as committed. The ring drains committed entries in order, at most one per cycle, onto a store-buffer write port that uses a valid/ready handshake and a byte mask.

A vector micro-op must reserve its entries before the number of active elements is known. Inactive elements are never sent down the address pipeline, so some reserved entries never receive a result. Each entry therefore carries three flags: a vector flag, an exception flag, and a vector-data-valid flag. The vector-data-valid flag is cleared when the entry is allocated. It is set only when the address pipeline writes back to an entry that is flagged as vector. An entry may write the store buffer only if it has no exception and is either scalar or has its vector-data-valid flag set. Any other entry leaves the ring silently: no write is issued and the payload outputs stay at zero.

A flush discards every uncommitted entry in one cycle. It does this by rewinding the enqueue pointer to the commit boundary.

Top module: `sq_vec`

## Requirements
- R1: After reset the queue is empty, `enq_ready` is 1, `enq_idx` is 0 and `sb_valid` is 0.
- R2: Each accepted enqueue returns the slot index in `enq_idx`; successive indices increase by one modulo 16. With 16 live entries `enq_ready` is 0, and a further enqueue is refused, leaving `enq_idx` unchanged.
- R3: A committed scalar entry writes the store buffer once, with the address, mask and data it received, and entries drain in allocation order.
- R4: A committed vector entry that received an address writeback (with no exception) writes the store buffer once.
- R5: A committed vector entry that never received an address writeback retires without any store-buffer write, and the entries behind it continue to drain.
- R6: A committed entry whose address writeback carried `sta_exc=1` retires without any store-buffer write.
- R7: While `sb_valid` is 1 and `sb_ready` is 0, `sb_valid` stays 1 and `sb_addr`, `sb_data` and `sb_mask` stay stable. The head advances only on acceptance.
- R8: A flush discards all uncommitted entries in one cycle. Afterwards `enq_idx` equals the index just past the last committed entry, and committed entries still drain.
- R9: An address or data writeback aimed at a slot that is not allocated is ignored. This includes a writeback to the slot being allocated in the same cycle.
- R10: Whenever `sb_valid` is 0, `sb_data` and `sb_mask` are 0.
- R11: A commit pulse while no uncommitted entry exists has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enq_valid | input | 1 | Dispatch requests one entry |
| enq_vec | input | 1 | Entry belongs to a vector store |
| enq_ready | output | 1 | Ring not full |
| enq_idx | output | 4 | Slot that the next enqueue takes |
| sta_valid | input | 1 | Address writeback valid |
| sta_idx | input | 4 | Address writeback slot |
| sta_addr | input | 32 | Store address |
| sta_mask | input | 8 | Byte mask |
| sta_exc | input | 1 | Address raised an exception |
| std_valid | input | 1 | Data writeback valid |
| std_idx | input | 4 | Data writeback slot |
| std_data | input | 64 | Store data |
| commit | input | 1 | Commit the oldest uncommitted entry |
| flush | input | 1 | Discard all uncommitted entries |
| sb_valid | output | 1 | Store-buffer write valid |
| sb_ready | input | 1 | Store buffer accepts |
| sb_addr | output | 32 | Write address |
| sb_data | output | 64 | Write data, zero when idle |
| sb_mask | output | 8 | Write mask, zero when idle |
| empty | output | 1 | No live entries |

## Verification
The properties assume that commit is pulsed only for entries whose writebacks have already arrived. They also assume that flush never coincides with an enqueue or a commit that must take effect, because flush takes priority and drops both. The stimulus issues every writeback in full before the matching commit, and it drives flush in a cycle on its own. The only deliberate exceptions are the cases where a stray commit or a writeback to a free slot is applied on purpose.

// File: rtl/sq_vec.sv
module sq_vec #(
  parameter int DEPTH = 16,
  parameter int AW = 32,
  parameter int DW = 64,
  localparam int IW = $clog2(DEPTH),
  localparam int MW = DW / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enq_valid,
  input  logic          enq_vec,
  output logic          enq_ready,
  output logic [IW-1:0] enq_idx,
  input  logic          sta_valid,
  input  logic [IW-1:0] sta_idx,
  input  logic [AW-1:0] sta_addr,
  input  logic [MW-1:0] sta_mask,
  input  logic          sta_exc,
  input  logic          std_valid,
  input  logic [IW-1:0] std_idx,
  input  logic [DW-1:0] std_data,
  input  logic          commit,
  input  logic          flush,
  output logic          sb_valid,
  input  logic          sb_ready,
  output logic [AW-1:0] sb_addr,
  output logic [DW-1:0] sb_data,
  output logic [MW-1:0] sb_mask,
  output logic          empty
);

  logic [IW:0] enq_ptr, cmt_ptr, deq_ptr;
  logic [IW:0] live_cnt;
  logic [DEPTH-1:0] alloc;

  logic [DEPTH-1:0] is_vec, exc, addr_ok, data_ok, vdv;
  logic [AW-1:0] addr_q [DEPTH];
  logic [MW-1:0] mask_q [DEPTH];
  logic [DW-1:0] data_q [DEPTH];

  logic full, enq_fire, cmt_fire, head_live, head_wr_ok, head_skip, deq_fire;
  logic [IW-1:0] head;

  assign live_cnt  = enq_ptr - deq_ptr;
  assign full      = (enq_ptr[IW] != deq_ptr[IW]) && (enq_ptr[IW-1:0] == deq_ptr[IW-1:0]);
  assign empty     = (enq_ptr == deq_ptr);
  assign enq_ready = !full;
  assign enq_idx   = enq_ptr[IW-1:0];
  assign enq_fire  = enq_valid && !full && !flush;
  assign cmt_fire  = commit && (cmt_ptr != enq_ptr) && !flush;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      logic [IW-1:0] off;
      off = IW'(i) - deq_ptr[IW-1:0];
      alloc[i] = ({1'b0, off} < live_cnt);
    end
  end

  assign head       = deq_ptr[IW-1:0];
  assign head_live  = (deq_ptr != cmt_ptr);
  assign head_wr_ok = !exc[head] && (!is_vec[head] || vdv[head]);
  assign sb_valid   = head_live && head_wr_ok && addr_ok[head] && data_ok[head];
  assign head_skip  = head_live && !head_wr_ok;
  assign deq_fire   = (sb_valid && sb_ready) || head_skip;

  assign sb_addr = sb_valid ? addr_q[head] : '0;
  assign sb_mask = sb_valid ? mask_q[head] : '0;
  assign sb_data = sb_valid ? data_q[head] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enq_ptr <= '0;
      cmt_ptr <= '0;
      deq_ptr <= '0;
    end else begin
      if (flush) enq_ptr <= cmt_ptr;
      else if (enq_fire) enq_ptr <= enq_ptr + 1'b1;
      if (cmt_fire) cmt_ptr <= cmt_ptr + 1'b1;
      if (deq_fire) deq_ptr <= deq_ptr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      is_vec  <= '0;
      exc     <= '0;
      addr_ok <= '0;
      data_ok <= '0;
      vdv     <= '0;
    end else begin
      if (enq_fire) begin
        is_vec[enq_idx]  <= enq_vec;
        exc[enq_idx]     <= 1'b0;
        addr_ok[enq_idx] <= 1'b0;
        data_ok[enq_idx] <= 1'b0;
        vdv[enq_idx]     <= 1'b0;
      end
      if (sta_valid && alloc[sta_idx]) begin
        addr_ok[sta_idx] <= 1'b1;
        exc[sta_idx]     <= sta_exc;
        if (is_vec[sta_idx]) vdv[sta_idx] <= 1'b1;
      end
      if (std_valid && alloc[std_idx]) data_ok[std_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (sta_valid && alloc[sta_idx]) begin
      addr_q[sta_idx] <= sta_addr;
      mask_q[sta_idx] <= sta_mask;
    end
    if (std_valid && alloc[std_idx]) data_q[std_idx] <= std_data;
  end

endmodule

// File: rtl/sq_vec_chk.sv
module sq_vec_chk #(
  parameter int IW = 4,
  parameter int AW = 32,
  parameter int DW = 64,
  localparam int MW = DW / 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          enq_valid,
  input logic          enq_ready,
  input logic [IW-1:0] enq_idx,
  input logic          flush,
  input logic          sb_valid,
  input logic          sb_ready,
  input logic [AW-1:0] sb_addr,
  input logic [DW-1:0] sb_data,
  input logic [MW-1:0] sb_mask,
  input logic          empty,
  input logic [IW:0]   cmt_ptr,
  input logic [IW:0]   deq_ptr
);

  p_refuse_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
    enq_valid && !enq_ready && !flush |=> $stable(enq_idx));

  p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !sb_valid |-> (sb_data == '0) && (sb_mask == '0));

  p_hold_payload_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sb_valid && !sb_ready |=> sb_valid && $stable(sb_addr) && $stable(sb_data) && $stable(sb_mask));

  p_flush_rewind_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> enq_idx == $past(cmt_ptr[IW-1:0]));

  p_empty_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !sb_valid);

  p_in_order_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (deq_ptr == $past(deq_ptr)) || (deq_ptr == $past(deq_ptr) + 1'b1));

endmodule

bind sq_vec sq_vec_chk #(.IW(IW), .AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_ready(enq_ready),
  .enq_idx(enq_idx), .flush(flush), .sb_valid(sb_valid), .sb_ready(sb_ready),
  .sb_addr(sb_addr), .sb_data(sb_data), .sb_mask(sb_mask), .empty(empty),
  .cmt_ptr(cmt_ptr), .deq_ptr(deq_ptr)
);

// File: tb/sim_sq_vec.sv
module sim_sq_vec;
  localparam int PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic enq_valid = 0, enq_vec = 0, enq_ready;
  logic [3:0] enq_idx;
  logic sta_valid = 0, sta_exc = 0;
  logic [3:0] sta_idx = 0;
  logic [31:0] sta_addr = 0;
  logic [7:0] sta_mask = 0;
  logic std_valid = 0;
  logic [3:0] std_idx = 0;
  logic [63:0] std_data = 0;
  logic commit = 0, flush = 0, sb_ready = 0;
  logic sb_valid, empty;
  logic [31:0] sb_addr;
  logic [63:0] sb_data;
  logic [7:0] sb_mask;

  typedef struct packed { logic [31:0] a; logic [63:0] d; logic [7:0] m; } item_t;
  item_t sb_q[$];
  int checks = 0, fails = 0;

  always #(PERIOD/2) clk = ~clk;

  sq_vec u0 (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && sb_valid && sb_ready) begin
      if (sb_q.size() == 0) chk(0, "R5/R6/R9 unexpected write", {32'h0, sb_addr}, 64'h0);
      else begin
        item_t e;
        e = sb_q.pop_front();
        chk(sb_addr == e.a, "R3/R4 addr", {32'h0, sb_addr}, {32'h0, e.a});
        chk(sb_data == e.d, "R3/R4 data", sb_data, e.d);
        chk(sb_mask == e.m, "R3/R4 mask", {56'h0, sb_mask}, {56'h0, e.m});
      end
    end
  end

  task automatic tick; @(posedge clk); #1; endtask

  task automatic do_enq(input bit vec, output logic [3:0] idx);
    enq_valid = 1; enq_vec = vec; idx = enq_idx;
    tick;
    enq_valid = 0;
  endtask

  task automatic do_sta(input logic [3:0] i, input logic [31:0] a, input logic [7:0] m, input bit e);
    sta_valid = 1; sta_idx = i; sta_addr = a; sta_mask = m; sta_exc = e;
    tick;
    sta_valid = 0; sta_exc = 0;
  endtask

  task automatic do_std(input logic [3:0] i, input logic [63:0] d);
    std_valid = 1; std_idx = i; std_data = d;
    tick;
    std_valid = 0;
  endtask

  task automatic do_commit; commit = 1; tick; commit = 0; endtask

  task automatic full_store(input bit vec, input logic [31:0] a, input logic [63:0] d, input logic [7:0] m);
    logic [3:0] i;
    do_enq(vec, i);
    do_sta(i, a, m, 0);
    do_std(i, d);
    do_commit;
    sb_q.push_back('{a, d, m});
  endtask

  task automatic wait_drain(input string req);
    for (int k = 0; k < 60 && !empty; k++) tick;
    tick;
    chk(empty, req, {63'h0, empty}, 64'h1);
    chk(sb_q.size() == 0, req, sb_q.size(), 0);
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    #(PERIOD * 100000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run;
  end

  initial begin
    logic [3:0] i0, i1, i2, i3, st;
    #(PERIOD * 3 + 1);
    chk(enq_ready && empty && !sb_valid, "R1 reset flags", {enq_ready, empty, sb_valid}, 3'b110);
    chk(enq_idx == 0, "R1 reset index", enq_idx, 0);
    rst_n = 1;
    tick;
    sb_ready = 1;

    // R3 scalar in-order drain
    full_store(0, 32'h1000, 64'h1111_2222_3333_4444, 8'hff);
    full_store(0, 32'h1008, 64'h5555_6666_7777_8888, 8'h0f);
    full_store(0, 32'h1010, 64'h9999_aaaa_bbbb_cccc, 8'hf0);
    wait_drain("R3 scalar drain");

    // R4/R5 vector group, two active of four
    do_enq(1, i0); do_enq(1, i1); do_enq(1, i2); do_enq(1, i3);
    do_sta(i0, 32'h2000, 8'h03, 0);
    do_sta(i2, 32'h2010, 8'h30, 0);
    do_std(i0, 64'hA0); do_std(i1, 64'hA1); do_std(i2, 64'hA2); do_std(i3, 64'hA3);
    sb_q.push_back('{32'h2000, 64'hA0, 8'h03});
    sb_q.push_back('{32'h2010, 64'hA2, 8'h30});
    repeat (4) do_commit;
    full_store(0, 32'h2100, 64'hBEEF, 8'h01);
    wait_drain("R4 R5 vector skip");

    // R6 exception entry retires silently
    do_enq(0, i0);
    do_sta(i0, 32'h3000, 8'hff, 1);
    do_std(i0, 64'hDEAD);
    do_commit;
    full_store(0, 32'h3008, 64'hC0DE, 8'h0c);
    wait_drain("R6 exception skip");

    // R7 backpressure
    sb_ready = 0;
    full_store(0, 32'h4000, 64'h4444, 8'h55);
    tick; tick;
    chk(sb_valid && sb_addr == 32'h4000, "R7 held", {31'h0, sb_valid, sb_addr}, {32'h1, 32'h4000});
    tick; tick; tick;
    chk(sb_valid && sb_addr == 32'h4000 && sb_data == 64'h4444, "R7 stable", sb_data, 64'h4444);
    chk(!empty, "R7 no advance", {63'h0, empty}, 0);
    sb_ready = 1;
    wait_drain("R7 release");

    // R8 flush
    do_enq(0, i0); do_enq(0, i1); do_enq(0, i2);
    do_sta(i0, 32'h5000, 8'h11, 0); do_std(i0, 64'h50);
    do_sta(i1, 32'h5008, 8'h22, 0); do_std(i1, 64'h51);
    do_sta(i2, 32'h5010, 8'h33, 0); do_std(i2, 64'h52);
    sb_ready = 0;
    do_commit;
    sb_q.push_back('{32'h5000, 64'h50, 8'h11});
    flush = 1; tick; flush = 0;
    chk(enq_idx == i1, "R8 rewind", enq_idx, i1);
    sb_ready = 1;
    wait_drain("R8 committed drain");

    // R2 fill and refuse
    st = enq_idx;
    for (int k = 0; k < 16; k++) begin
      logic [3:0] got;
      do_enq(0, got);
      chk(got == 4'(st + k), "R2 index sequence", got, 4'(st + k));
    end
    chk(!enq_ready, "R2 full", {63'h0, enq_ready}, 0);
    enq_valid = 1; tick; enq_valid = 0;
    chk(enq_idx == st, "R2 refused", enq_idx, st);
    flush = 1; tick; flush = 0;
    chk(empty && enq_ready, "R2 flush to empty", {empty, enq_ready}, 2'b11);

    // R9 writeback to slot being allocated is ignored
    enq_valid = 1; enq_vec = 1; i0 = enq_idx;
    sta_valid = 1; sta_idx = i0; sta_addr = 32'h6000; sta_mask = 8'hff;
    std_valid = 1; std_idx = i0; std_data = 64'h66;
    tick;
    enq_valid = 0; sta_valid = 0; std_valid = 0;
    do_commit;
    wait_drain("R9 ignored writeback");

    // R11 stray commit ignored
    do_commit;
    do_enq(0, i0);
    do_sta(i0, 32'h7000, 8'h77, 0);
    do_std(i0, 64'h77);
    tick; tick; tick;
    chk(!sb_valid, "R11 no commit", {63'h0, sb_valid}, 0);
    chk(sb_data == 0 && sb_mask == 0, "R10 idle zero", sb_data, 0);
    do_commit;
    sb_q.push_back('{32'h7000, 64'h77, 8'h77});
    wait_drain("R11 drain");
    chk(sb_data == 0 && sb_mask == 0 && !sb_valid, "R10 idle after drain", sb_data, 0);

    finish_run;
  end
endmodule